// File: doc/BRIEF.md
# Store Buffer with Selectable Memory Ordering

This block sits between a single processor's load/store port and a single-ported memory. Stores are parked in a small write buffer so the processor does not wait for write latency. The buffer then drains to memory in the background. Loads first search the buffer, and a hit is answered from the youngest buffered store. How far loads and stores may overtake one another depends on a 2-bit ordering mode: sequential, total-store or partial-store.

The processor can also issue three fence flavours (full, load-only, store-only) and an atomic exchange. The exchange first waits for all older traffic to finish. It then reads and writes one location as an indivisible pair.

The processor side is a valid/ready request with a one-cycle response pulse. The memory side is a request with a valid/ready handshake followed by a response pulse after a variable delay. Only one memory transaction is open at any time. Loads are blocking: once a load goes to memory, no further operation is accepted until its data returns.

Top module: `stbuf_order`

## Requirements
- R1: After reset, mem_req_valid and cpu_resp_valid are low and a load (op 0) is accepted at once in the default sequential mode (mode 0).
- R2: In sequential mode (mode 0, or 3), a load or store (op 1) is accepted only when no store is buffered and no memory transaction is open, so a store's write response precedes any later access.
- R3: A load whose address matches buffered stores is accepted without waiting, issues no memory read, and returns the youngest matching store's data with cpu_resp_valid in the cycle after acceptance.
- R4: In total-store mode (mode 1), a load that misses the buffer goes to memory ahead of any buffered store that has not yet been sent.
- R5: In sequential and total-store modes, buffered stores reach memory in program order; every load returns the value of the last older store to its address.
- R6: In partial-store mode (mode 2), the next store sent is the youngest buffered entry that has no older entry to the same address, so same-address stores keep program order.
- R7: A full fence (op 2) is accepted only once every older store has received its write response and no transaction is open.
- R8: A load-only fence (op 3) is accepted in the cycle it is presented, even with stores buffered and memory stalled, and leaves those stores buffered.
- R9: A store-only fence (op 4) is accepted only once the buffer has drained and the last write response has arrived.
- R10: An exchange (op 5) waits until all older stores are written. It then issues a read and a write to its address back to back, returns the old value and leaves the new one in memory.
- R11: The buffer holds 4 stores; a store presented while 4 are buffered is not accepted.
- R12: The data of a load that went to memory appears on cpu_resp_data with cpu_resp_valid one cycle after the memory response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ord_mode | input | 2 | Ordering: 0 sequential, 1 total-store, 2 partial-store; change only when idle |
| cpu_req_valid | input | 1 | Processor operation present |
| cpu_req_op | input | 3 | 0 load, 1 store, 2 full fence, 3 load fence, 4 store fence, 5 exchange |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Store or exchange data |
| cpu_req_ready | output | 1 | Operation accepted this cycle when valid |
| cpu_resp_valid | output | 1 | One-cycle pulse with load or exchange data |
| cpu_resp_data | output | DW | Returned data |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Write data |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_resp_valid | input | 1 | One-cycle completion pulse, at least one cycle after acceptance |
| mem_resp_data | input | DW | Read data |

## Verification
A forwarded load must show its response at the first sample after the acceptance edge. A load that goes to memory must show its response exactly one cycle after the memory model drives its response pulse. The bench records the cycle of every memory response and compares against that count. Fence and exchange timing is judged by counting write responses at the moment of acceptance. Ordering is judged from a trace of memory transactions, which the bench records in the cycle each handshake completes. Inputs change only off the clock edge, and readiness is sampled just after the falling edge, once the request inputs have settled.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_FENCE_ALL = 3'd2,
    OP_FENCE_LD  = 3'd3,
    OP_FENCE_ST  = 3'd4,
    OP_XCHG      = 3'd5
  } op_e;

  localparam logic [1:0] MODE_SEQ = 2'd0;
  localparam logic [1:0] MODE_TSO = 2'd1;
  localparam logic [1:0] MODE_PSO = 2'd2;

  typedef enum logic [2:0] {
    ST_RUN, ST_LOAD, ST_XRD, ST_XWI, ST_XWW
  } ctl_state_e;
endpackage

// File: rtl/stbuf_entries.sv
module stbuf_entries #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [IW-1:0] pop_idx,
  input  logic          pso_pick,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [DW-1:0] look_data,
  output logic          empty,
  output logic          full,
  output logic [IW-1:0] pick_idx,
  output logic [AW-1:0] pick_addr,
  output logic [DW-1:0] pick_data
);
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] wr_idx;
  logic          pick_ok;

  assign wr_idx = IW'(cnt - CW'(pop));
  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(push) - CW'(pop);
  end

  // entry 0 is always the oldest; removal compacts younger entries down
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (pop && (IW'(i) >= pop_idx)) begin
        ent_addr[i] <= ent_addr[i+1];
        ent_data[i] <= ent_data[i+1];
      end
    end
    if (push) begin
      ent_addr[wr_idx] <= push_addr;
      ent_data[wr_idx] <= push_data;
    end
  end

  // youngest matching entry wins
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt) && (ent_addr[i] == look_addr)) begin
        look_hit  = 1'b1;
        look_data = ent_data[i];
      end
    end
  end

  // drain choice: oldest, or youngest entry with no older same-address entry
  always_comb begin
    pick_idx = '0;
    pick_ok  = 1'b0;
    if (pso_pick) begin
      for (int i = 0; i < DEPTH; i++) begin
        pick_ok = (CW'(i) < cnt);
        for (int j = 0; j < i; j++) begin
          if (ent_addr[j] == ent_addr[i]) pick_ok = 1'b0;
        end
        if (pick_ok) pick_idx = IW'(i);
      end
    end
  end

  assign pick_addr = ent_addr[pick_idx];
  assign pick_data = ent_data[pick_idx];

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/stbuf_memseq.sv
module stbuf_memseq #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_req_ready,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data
);
  assign done      = busy && !mem_req_valid && mem_resp_valid;
  assign done_data = mem_resp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else if (start) begin
      busy          <= 1'b1;
      mem_req_valid <= 1'b1;
      mem_req_we    <= start_we;
      mem_req_addr  <= start_addr;
      mem_req_wdata <= start_wdata;
    end else begin
      if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
      if (done) busy <= 1'b0;
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  a_r2_one_open: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/stbuf_order.sv
module stbuf_order
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ord_mode,
  input  logic          cpu_req_valid,
  input  logic [2:0]    cpu_req_op,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_req_ready,
  output logic          cpu_resp_valid,
  output logic [DW-1:0] cpu_resp_data,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_req_ready,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data
);
  ctl_state_e    state;
  logic          seq_mode, pso_mode, quiet, acc;
  logic          buf_empty, buf_full, look_hit;
  logic [DW-1:0] look_data, pick_data;
  logic [AW-1:0] pick_addr;
  logic [IW-1:0] pick_idx, drain_idx;
  logic          drain_q, drain_go;
  logic          eng_busy, eng_done, eng_start, eng_we;
  logic [AW-1:0] eng_addr, x_addr;
  logic [DW-1:0] eng_wdata, eng_rdata, x_data;

  assign pso_mode = (ord_mode == MODE_PSO);
  assign seq_mode = !(ord_mode == MODE_TSO || pso_mode);
  assign quiet    = buf_empty && !eng_busy;

  always_comb begin
    cpu_req_ready = 1'b0;
    if (state == ST_RUN) begin
      case (cpu_req_op)
        OP_LOAD:      cpu_req_ready = seq_mode ? quiet : (look_hit || !eng_busy);
        OP_STORE:     cpu_req_ready = seq_mode ? quiet : !buf_full;
        OP_FENCE_ALL: cpu_req_ready = quiet;
        OP_FENCE_LD:  cpu_req_ready = 1'b1;
        OP_FENCE_ST:  cpu_req_ready = quiet;
        OP_XCHG:      cpu_req_ready = quiet;
        default:      cpu_req_ready = 1'b0;
      endcase
    end
  end
  assign acc = cpu_req_valid && cpu_req_ready;

  // memory port arbitration: load miss / exchange before background drain
  always_comb begin
    eng_start = 1'b0;
    eng_we    = 1'b0;
    eng_addr  = cpu_req_addr;
    eng_wdata = cpu_req_wdata;
    drain_go  = 1'b0;
    if (!eng_busy) begin
      if (state == ST_RUN && acc && cpu_req_op == OP_LOAD && !look_hit) begin
        eng_start = 1'b1;
      end else if (state == ST_RUN && acc && cpu_req_op == OP_XCHG) begin
        eng_start = 1'b1;
      end else if (state == ST_XWI) begin
        eng_start = 1'b1;
        eng_we    = 1'b1;
        eng_addr  = x_addr;
        eng_wdata = x_data;
      end else if (state == ST_RUN && !buf_empty) begin
        eng_start = 1'b1;
        eng_we    = 1'b1;
        eng_addr  = pick_addr;
        eng_wdata = pick_data;
        drain_go  = 1'b1;
      end
    end
  end

  stbuf_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
    .clk(clk), .rst(rst),
    .push(acc && cpu_req_op == OP_STORE), .push_addr(cpu_req_addr), .push_data(cpu_req_wdata),
    .pop(eng_done && drain_q), .pop_idx(drain_idx), .pso_pick(pso_mode),
    .look_addr(cpu_req_addr), .look_hit(look_hit), .look_data(look_data),
    .empty(buf_empty), .full(buf_full),
    .pick_idx(pick_idx), .pick_addr(pick_addr), .pick_data(pick_data)
  );

  stbuf_memseq #(.AW(AW), .DW(DW)) u_memseq (
    .clk(clk), .rst(rst),
    .start(eng_start), .start_we(eng_we), .start_addr(eng_addr), .start_wdata(eng_wdata),
    .busy(eng_busy), .done(eng_done), .done_data(eng_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_RUN;
      drain_q        <= 1'b0;
      drain_idx      <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_data  <= '0;
      x_addr         <= '0;
      x_data         <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      if (drain_go) begin
        drain_q   <= 1'b1;
        drain_idx <= pick_idx;
      end else if (eng_done && drain_q) begin
        drain_q <= 1'b0;
      end
      case (state)
        ST_RUN: begin
          if (acc && cpu_req_op == OP_LOAD) begin
            if (look_hit) begin
              cpu_resp_valid <= 1'b1;
              cpu_resp_data  <= look_data;
            end else begin
              state <= ST_LOAD;
            end
          end else if (acc && cpu_req_op == OP_XCHG) begin
            state  <= ST_XRD;
            x_addr <= cpu_req_addr;
            x_data <= cpu_req_wdata;
          end
        end
        ST_LOAD: if (eng_done) begin
          cpu_resp_valid <= 1'b1;
          cpu_resp_data  <= eng_rdata;
          state          <= ST_RUN;
        end
        ST_XRD: if (eng_done) begin
          cpu_resp_data <= eng_rdata;
          state         <= ST_XWI;
        end
        ST_XWI: if (!eng_busy) state <= ST_XWW;
        ST_XWW: if (eng_done) begin
          cpu_resp_valid <= 1'b1;
          state          <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  a_r2_seq_single: assert property (@(posedge clk) disable iff (rst)
    (seq_mode && acc && (cpu_req_op == OP_LOAD || cpu_req_op == OP_STORE)) |-> (buf_empty && !eng_busy));
  a_r7_fence_drained: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_req_op == OP_FENCE_ALL) |-> (buf_empty && !mem_req_valid && !eng_busy));
  a_r3_fwd_next: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_req_op == OP_LOAD && look_hit) |=> cpu_resp_valid);
  a_r12_load_resp: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && mem_resp_valid && !mem_req_valid) |=> cpu_resp_valid);
  a_r10_xchg_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XWI) |=> (mem_req_valid && mem_req_we && mem_req_addr == x_addr));
endmodule

// File: tb/stbuf_order_tb.sv
`timescale 1ns/1ps
module stbuf_order_tb;
  import stbuf_pkg::*;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] ord_mode = MODE_SEQ;
  logic cpu_req_valid = 1'b0;
  logic [2:0] cpu_req_op = 3'd0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_resp_valid;
  logic [DW-1:0] cpu_resp_data;
  logic mem_req_valid, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_req_ready, mem_resp_valid;
  logic [DW-1:0] mem_resp_data;

  stbuf_order #(.DEPTH(4), .AW(AW), .DW(DW)) u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] mem_arr [16];
  logic [DW-1:0] ref_arr [16];
  bit            tr_we   [256];
  int            tr_addr [256];
  logic [DW-1:0] tr_data [256];
  int tr_n = 0, wr_done = 0, rd_resp_cyc = 0, lat = 1, pend = 0;
  bit mem_hold = 0, mem_rand = 0, pend_we = 0;
  logic [DW-1:0] pend_data = '0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // memory model: decides ready at the falling edge, logs accepted requests
  initial begin
    bit rdy;
    for (int i = 0; i < 16; i++) mem_arr[i] = '0;
    mem_req_ready = 0; mem_resp_valid = 0; mem_resp_data = '0;
    forever begin
      @(negedge clk);
      mem_resp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_resp_valid = 1;
          mem_resp_data  = pend_data;
          if (pend_we) wr_done++; else rd_resp_cyc = cyc;
        end
      end
      rdy = !mem_hold && (pend == 0) && (!mem_rand || ($urandom % 2 == 0));
      mem_req_ready = rdy;
      if (mem_req_valid && rdy) begin
        tr_we[tr_n % 256] = mem_req_we;
        tr_addr[tr_n % 256] = int'(mem_req_addr[3:0]);
        tr_data[tr_n % 256] = mem_req_wdata;
        tr_n++;
        if (mem_req_we) mem_arr[mem_req_addr[3:0]] = mem_req_wdata;
        else pend_data = mem_arr[mem_req_addr[3:0]];
        pend_we = mem_req_we;
        pend = 1 + int'($urandom % lat);
      end
    end
  end

  task automatic op_go(input op_e op, input int a, input logic [DW-1:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = op; cpu_req_addr = AW'(a); cpu_req_wdata = d;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; waits++; end
    @(posedge clk);
    if (op == OP_STORE) ref_arr[a] = d;
    #1 cpu_req_valid = 0;
  endtask

  task automatic wait_resp(output logic [DW-1:0] d, output int first);
    first = 0;
    @(negedge clk);
    while (!cpu_resp_valid && first < 300) begin first++; @(negedge clk); end
    if (first >= 300) chk(0, "R3 response timeout", first, 0);
    d = cpu_resp_data;
  endtask

  task automatic hold_release_after(input int n);
    repeat (n) @(posedge clk);
    #1 mem_hold = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int w, f, t0, w0;
    logic [DW-1:0] d, e;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) ref_arr[i] = '0;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    chk(mem_req_valid == 0, "R1 mem_req_valid", mem_req_valid, 0);
    chk(cpu_resp_valid == 0, "R1 cpu_resp_valid", cpu_resp_valid, 0);
    chk(cpu_req_ready == 1, "R1 load ready", cpu_req_ready, 1);

    // R4 R12: load miss overtakes queued stores in total-store mode
    ord_mode = MODE_TSO; lat = 1; mem_hold = 1; t0 = tr_n;
    op_go(OP_STORE, 1, 32'h11, w); op_go(OP_STORE, 2, 32'h22, w); op_go(OP_STORE, 3, 32'h33, w);
    fork op_go(OP_LOAD, 5, 0, w); hold_release_after(6); join
    wait_resp(d, f);
    chk(d == ref_arr[5], "R4 load data", d, ref_arr[5]);
    chk(cyc == rd_resp_cyc + 1, "R12 response cycle", cyc, rd_resp_cyc + 1);
    op_go(OP_FENCE_ALL, 0, 0, w);
    chk(tr_we[t0] && tr_addr[t0] == 1, "R5 first write", tr_addr[t0], 1);
    chk(!tr_we[t0+1] && tr_addr[t0+1] == 5, "R4 read overtakes", tr_addr[t0+1], 5);
    chk(tr_we[t0+2] && tr_addr[t0+2] == 2 && tr_we[t0+3] && tr_addr[t0+3] == 3,
        "R5 remaining order", tr_addr[t0+2], 2);

    // R11 R8 R7: capacity, load fence, full fence
    #1 mem_hold = 1; w0 = wr_done;
    for (int i = 1; i <= 4; i++) op_go(OP_STORE, i, DW'(i * 16), w);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = OP_STORE; cpu_req_addr = 6; cpu_req_wdata = 32'h66;
    f = 0;
    for (int i = 0; i < 3; i++) begin #1; if (cpu_req_ready) f++; @(negedge clk); end
    cpu_req_valid = 0;
    chk(f == 0, "R11 store refused when full", f, 0);
    op_go(OP_FENCE_LD, 0, 0, w);
    chk(w == 0, "R8 load fence immediate", w, 0);
    chk(wr_done == w0, "R8 stores still buffered", wr_done - w0, 0);
    #1 mem_hold = 0;
    op_go(OP_FENCE_ALL, 0, 0, w);
    chk(wr_done - w0 == 4, "R7 fence after all writes", wr_done - w0, 4);
    op_go(OP_STORE, 6, 32'h66, w);
    op_go(OP_FENCE_ALL, 0, 0, w);

    // R6: partial-store drain choice
    ord_mode = MODE_PSO; #1 mem_hold = 1; t0 = tr_n;
    op_go(OP_STORE, 1, 32'h10, w); op_go(OP_STORE, 2, 32'h20, w);
    op_go(OP_STORE, 3, 32'h30, w); op_go(OP_STORE, 2, 32'h21, w);
    #1 mem_hold = 0;
    op_go(OP_FENCE_ALL, 0, 0, w);
    chk(tr_addr[t0] == 1 && tr_data[t0] == 32'h10, "R6 drain 0", tr_addr[t0], 1);
    chk(tr_addr[t0+1] == 3 && tr_data[t0+1] == 32'h30, "R6 youngest eligible", tr_addr[t0+1], 3);
    chk(tr_addr[t0+2] == 2 && tr_data[t0+2] == 32'h20, "R6 same-address older", tr_data[t0+2], 32'h20);
    chk(tr_addr[t0+3] == 2 && tr_data[t0+3] == 32'h21, "R6 same-address younger", tr_data[t0+3], 32'h21);
    chk(mem_arr[2] == 32'h21, "R6 final value", mem_arr[2], 32'h21);

    // R3: forwarding with memory stalled
    ord_mode = MODE_TSO; #1 mem_hold = 1; t0 = tr_n;
    op_go(OP_STORE, 7, 32'h55, w); op_go(OP_STORE, 7, 32'h66, w);
    op_go(OP_LOAD, 7, 0, w);
    chk(w == 0, "R3 accepted without wait", w, 0);
    wait_resp(d, f);
    chk(f == 0, "R3 one-cycle latency", f, 0);
    chk(d == 32'h66, "R3 youngest data", d, 32'h66);
    #1 mem_hold = 0;
    op_go(OP_FENCE_ALL, 0, 0, w);
    f = 0;
    for (int i = t0; i < tr_n; i++) if (!tr_we[i % 256]) f++;
    chk(f == 0, "R3 no memory read", f, 0);

    // R2: sequential mode serialises store then load
    ord_mode = MODE_SEQ; lat = 3; t0 = tr_n; w0 = wr_done;
    op_go(OP_STORE, 8, 32'h88, w);
    op_go(OP_LOAD, 8, 0, w);
    chk(wr_done - w0 == 1, "R2 write done before load", wr_done - w0, 1);
    chk(w > 0, "R2 load waited", w, 1);
    wait_resp(d, f);
    chk(d == 32'h88, "R2 load data", d, 32'h88);
    chk(tr_we[t0] && !tr_we[t0+1] && tr_addr[t0+1] == 8, "R2 trace order", tr_we[t0+1], 0);

    // R10: exchange
    ord_mode = MODE_TSO; lat = 1; #1 mem_hold = 1; t0 = tr_n;
    op_go(OP_STORE, 9, 32'h5, w); op_go(OP_STORE, 10, 32'h6, w);
    fork op_go(OP_XCHG, 9, 32'h77, w); hold_release_after(4); join
    ref_arr[9] = 32'h77;
    wait_resp(d, f);
    chk(d == 32'h5, "R10 old value", d, 32'h5);
    chk(tr_addr[t0] == 9 && tr_addr[t0+1] == 10, "R10 older writes first", tr_addr[t0+1], 10);
    chk(!tr_we[t0+2] && tr_addr[t0+2] == 9 && tr_we[t0+3] && tr_addr[t0+3] == 9 && tr_data[t0+3] == 32'h77,
        "R10 read then write", tr_data[t0+3], 32'h77);
    chk(mem_arr[9] == 32'h77, "R10 new value", mem_arr[9], 32'h77);

    // R9: store fence waits for drain
    #1 mem_hold = 1; w0 = wr_done;
    op_go(OP_STORE, 11, 32'hB, w);
    fork op_go(OP_FENCE_ST, 0, 0, w); hold_release_after(5); join
    chk(wr_done - w0 == 1, "R9 fence after write", wr_done - w0, 1);

    // random mix, R5 R3 R10 against reference memory
    mem_rand = 1; lat = 3;
    for (int blk = 0; blk < 6; blk++) begin
      ord_mode = 2'(blk % 3);
      for (int k = 0; k < 40; k++) begin
        int r, a;
        r = int'($urandom % 10); a = int'($urandom % 4);
        d = $urandom;
        if (r < 4) op_go(OP_STORE, a, d, w);
        else if (r < 7) begin
          e = ref_arr[a];
          op_go(OP_LOAD, a, 0, w); wait_resp(d, f);
          chk(d == e, "R5 random load value", d, e);
        end else if (r == 7) op_go(OP_FENCE_LD, 0, 0, w);
        else if (r == 8) op_go(OP_FENCE_ST, 0, 0, w);
        else begin
          e = ref_arr[a];
          op_go(OP_XCHG, a, d, w); ref_arr[a] = d; wait_resp(d, f);
          chk(d == e, "R10 random exchange value", d, e);
        end
      end
      op_go(OP_FENCE_ALL, 0, 0, w);
      for (int i = 0; i < 16; i++)
        chk(mem_arr[i] == ref_arr[i], "R6 final memory image", mem_arr[i], ref_arr[i]);
    end
    finish_run();
  end
endmodule